// File: doc/BRIEF.md
# ECC Control and Status Register Block with Write-Once Lock

This block holds the software-visible settings for error-correcting-code protection of five on-chip memories: the instruction local memory, the data local memory, the instruction cache, the data cache and the address translation buffer. Each memory has an ECC enable and a separate double-error trap enable. A shared injection register supplies a replacement check code and a select bit that tells memory write paths to use it instead of the generated code. The same register also carries sticky flags that record, per memory, whether a single-bit (corrected) or a double-bit (uncorrectable) error has been reported.

The block watches per-memory error event inputs. A double-bit event produces a one-cycle trap request for that memory only when the memory's ECC enable and trap enable are both set and the access could trap at all. Accesses from a slave port or a debug bus cannot trap, so they raise the flag but no request. The trap unit reports each such request as an access fault and never as a page fault. Single-bit events only set a flag.

A lock state machine has two states. `LK_OPEN` is entered at reset. The transition `OPEN->SEALED` fires on an accepted write of 1 to bit 0 of the lock register. `LK_SEALED` has no exit other than reset. In `LK_SEALED` every write to the six ECC registers is dropped. Hardware error events keep updating the flags and keep raising trap requests.

Top module: `ecc_ctl_regs`

## Requirements
- R1: After reset all ECC enables, trap enables, the injection code, the select bit and every status flag are 0, the block is unlocked, `exc_req` is 0, and every register reads back 0.
- R2: Control registers sit at 0x7C0 (instruction local memory), 0x7C1 (data local memory), 0x7CA (instruction cache in bits 1:0, data cache in bits 3:2) and 0x7DD (translation buffer). In each pair the lower bit is the ECC enable and the upper bit is the trap enable. Other bits read 0. A read request returns its data on `csr_rdata` with `csr_rvalid` high exactly one cycle later.
- R3: Register 0x7C2 holds the injection code in bits 7:0 and the select bit in bit 8, driven on `inj_code` and `inj_sel`.
- R4: A single-bit event on memory i sets correctable flag bit 16+i of 0x7C2 and never raises `exc_req`. Memory index order is: 0 instruction local memory, 1 data local memory, 2 instruction cache, 3 data cache, 4 translation buffer.
- R5: A double-bit event on memory i sets uncorrectable flag bit 24+i of 0x7C2 whatever the enables and `dbe_trap_ok` are.
- R6: `exc_req[i]` is high in the cycle after a double-bit event on memory i exactly when `dbe_trap_ok[i]`, the ECC enable and the trap enable of memory i are all set.
- R7: A flag is cleared only by an accepted write to 0x7C2 carrying 0 in its bit. Writing 1 leaves the flag unchanged. An event in the same cycle as the clear wins.
- R8: Writing 1 to bit 0 of 0x7DE seals the block, which is shown on `ecc_locked` and on read bit 0. Writing 0 has no effect, and the sealed state is left only by reset.
- R9: While sealed, writes to all six ECC addresses (including the flag clears and the lock register) are ignored. Error events still set flags and raise `exc_req`.
- R10: Any other address leaves `csr_hit` low, reads as 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | CSR access strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| csr_hit | output | 1 | Address belongs to this block |
| csr_rvalid | output | 1 | Read data valid, one cycle after a read request |
| csr_rdata | output | 32 | Read data |
| sbe_evt | input | 5 | Per-memory single-bit error event |
| dbe_evt | input | 5 | Per-memory double-bit error event |
| dbe_trap_ok | input | 5 | Event came from an access that may trap |
| ecc_en | output | 5 | Per-memory ECC enable |
| inj_code | output | 8 | Injection check code |
| inj_sel | output | 1 | Use injection code on writes |
| exc_req | output | 5 | Per-memory trap request (access fault) |
| ecc_locked | output | 1 | Block is sealed |

## Verification
The bound checker watches the following on every cycle:
- the read-response timing;
- that a trap request always follows a trap-eligible, enabled double-bit event;
- that a single-bit event alone never yields one;
- that uncorrectable flags rise after double-bit events;
- that the seal never drops;
- that configuration outputs hold still while sealed;
- that unknown addresses read 0.

Only the bench scenarios can show:
- the exact register layout and readback values;
- that a clear-by-zero and a same-cycle event resolve in favour of the event;
- that the trap enable is truly separate from the ECC enable;
- that writing 0 to the lock, or writing any ECC register after sealing, leaves every value intact.

// File: rtl/ecc_ctl_pkg.sv
package ecc_ctl_pkg;

    localparam int NUM_MEM  = 5;
    localparam int XLEN     = 32;
    localparam int CODE_W   = 8;
    localparam int SEL_BIT  = CODE_W;
    localparam int COR_BASE = 16;
    localparam int UNC_BASE = 24;

    localparam logic [11:0] A_ILM   = 12'h7C0;
    localparam logic [11:0] A_DLM   = 12'h7C1;
    localparam logic [11:0] A_INJ   = 12'h7C2;
    localparam logic [11:0] A_CACHE = 12'h7CA;
    localparam logic [11:0] A_TLB   = 12'h7DD;
    localparam logic [11:0] A_LOCK  = 12'h7DE;

    typedef enum logic [2:0] {
        M_ILM    = 3'd0,
        M_DLM    = 3'd1,
        M_ICACHE = 3'd2,
        M_DCACHE = 3'd3,
        M_TLB    = 3'd4
    } mem_id_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    // Address of the control register that carries memory m's enables.
    function automatic logic [11:0] ctl_addr(input int m);
        case (m)
            int'(M_ILM):    return A_ILM;
            int'(M_DLM):    return A_DLM;
            int'(M_ICACHE): return A_CACHE;
            int'(M_DCACHE): return A_CACHE;
            default:        return A_TLB;
        endcase
    endfunction

    // Bit position of memory m's ECC enable inside its control register.
    function automatic int ctl_base(input int m);
        return (m == int'(M_DCACHE)) ? 2 : 0;
    endfunction

endpackage

// File: rtl/ecc_ctl_lock_fsm.sv
module ecc_ctl_lock_fsm
    import ecc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_wr,
    output logic sealed
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sealed  = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                if (seal_wr) begin
                    state_d = LK_SEALED;
                end
            end
            LK_SEALED: begin
                sealed = 1'b1;
            end
            default: begin
                state_d = LK_SEALED;
            end
        endcase
    end

endmodule

// File: rtl/ecc_ctl_flags.sv
module ecc_ctl_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic [N-1:0] keep,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_wr && !keep[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ecc_ctl_trap_gate.sv
module ecc_ctl_trap_gate #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dbe,
    input  logic [N-1:0] trap_ok,
    input  logic [N-1:0] en,
    input  logic [N-1:0] xen,
    output logic [N-1:0] req
);

    for (genvar i = 0; i < N; i++) begin : g_gate
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req[i] <= 1'b0;
            end else begin
                req[i] <= dbe[i] && trap_ok[i] && en[i] && xen[i];
            end
        end
    end

endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
    import ecc_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_req,
    input  logic                 csr_we,
    input  logic [11:0]          csr_addr,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic                 csr_hit,
    output logic                 csr_rvalid,
    output logic [XLEN-1:0]      csr_rdata,
    input  logic [NUM_MEM-1:0]   sbe_evt,
    input  logic [NUM_MEM-1:0]   dbe_evt,
    input  logic [NUM_MEM-1:0]   dbe_trap_ok,
    output logic [NUM_MEM-1:0]   ecc_en,
    output logic [CODE_W-1:0]    inj_code,
    output logic                 inj_sel,
    output logic [NUM_MEM-1:0]   exc_req,
    output logic                 ecc_locked
);

    logic                sealed;
    logic                write_ok;
    logic                read_go;
    logic                inj_wr;
    logic                seal_wr;
    logic [NUM_MEM-1:0]  en_q;
    logic [NUM_MEM-1:0]  xen_q;
    logic [NUM_MEM-1:0]  cor_q;
    logic [NUM_MEM-1:0]  unc_q;
    logic [CODE_W-1:0]   code_q;
    logic                sel_q;
    logic [XLEN-1:0]     rd_mux;
    logic                unused_wdata;

    assign unused_wdata = ^csr_wdata;

    // Address decode
    always_comb begin
        case (csr_addr)
            A_ILM, A_DLM, A_INJ, A_CACHE, A_TLB, A_LOCK: csr_hit = 1'b1;
            default:                                      csr_hit = 1'b0;
        endcase
    end

    assign write_ok = csr_req && csr_we && csr_hit && !sealed;
    assign read_go  = csr_req && !csr_we;
    assign inj_wr   = write_ok && (csr_addr == A_INJ);
    assign seal_wr  = write_ok && (csr_addr == A_LOCK) && csr_wdata[0];

    ecc_ctl_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .seal_wr (seal_wr),
        .sealed  (sealed)
    );

    // Per-memory enable pairs
    for (genvar m = 0; m < NUM_MEM; m++) begin : g_ctl
        logic wr_this;
        assign wr_this = write_ok && (csr_addr == ctl_addr(m));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[m]  <= 1'b0;
                xen_q[m] <= 1'b0;
            end else if (wr_this) begin
                en_q[m]  <= csr_wdata[ctl_base(m)];
                xen_q[m] <= csr_wdata[ctl_base(m) + 1];
            end
        end
    end

    // Injection code and select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            sel_q  <= 1'b0;
        end else if (inj_wr) begin
            code_q <= csr_wdata[CODE_W-1:0];
            sel_q  <= csr_wdata[SEL_BIT];
        end
    end

    // Sticky status flags
    ecc_ctl_flags #(.N(NUM_MEM)) u_cor (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (sbe_evt),
        .clr_wr (inj_wr),
        .keep   (csr_wdata[COR_BASE +: NUM_MEM]),
        .flags  (cor_q)
    );

    ecc_ctl_flags #(.N(NUM_MEM)) u_unc (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (dbe_evt),
        .clr_wr (inj_wr),
        .keep   (csr_wdata[UNC_BASE +: NUM_MEM]),
        .flags  (unc_q)
    );

    // Trap request gating
    ecc_ctl_trap_gate #(.N(NUM_MEM)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbe     (dbe_evt),
        .trap_ok (dbe_trap_ok),
        .en      (en_q),
        .xen     (xen_q),
        .req     (exc_req)
    );

    // Read mux
    always_comb begin
        rd_mux = '0;
        if (csr_addr == A_INJ) begin
            rd_mux[CODE_W-1:0]           = code_q;
            rd_mux[SEL_BIT]              = sel_q;
            rd_mux[COR_BASE +: NUM_MEM]  = cor_q;
            rd_mux[UNC_BASE +: NUM_MEM]  = unc_q;
        end else if (csr_addr == A_LOCK) begin
            rd_mux[0] = sealed;
        end else begin
            for (int m = 0; m < NUM_MEM; m++) begin
                if (csr_addr == ctl_addr(m)) begin
                    rd_mux[ctl_base(m)]     = en_q[m];
                    rd_mux[ctl_base(m) + 1] = xen_q[m];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_rvalid <= 1'b0;
            csr_rdata  <= '0;
        end else begin
            csr_rvalid <= read_go;
            csr_rdata  <= read_go ? rd_mux : '0;
        end
    end

    assign ecc_en     = en_q;
    assign inj_code   = code_q;
    assign inj_sel    = sel_q;
    assign ecc_locked = sealed;

endmodule

// File: rtl/ecc_ctl_chk.sv
module ecc_ctl_chk
    import ecc_ctl_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                csr_req,
    input logic                csr_we,
    input logic                csr_hit,
    input logic                csr_rvalid,
    input logic [XLEN-1:0]     csr_rdata,
    input logic [NUM_MEM-1:0]  sbe_evt,
    input logic [NUM_MEM-1:0]  dbe_evt,
    input logic [NUM_MEM-1:0]  dbe_trap_ok,
    input logic [NUM_MEM-1:0]  ecc_en,
    input logic [CODE_W-1:0]   inj_code,
    input logic                inj_sel,
    input logic [NUM_MEM-1:0]  exc_req,
    input logic                ecc_locked,
    input logic [NUM_MEM-1:0]  unc_flags
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_we) |=> csr_rvalid);

    assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_we && !csr_hit) |=> (csr_rdata == '0));

    assert_seal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_locked |=> ecc_locked);

    assert_sealed_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_locked |=> ($stable(ecc_en) && $stable(inj_code) && $stable(inj_sel)));

    for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
        assert_trap_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            exc_req[i] |-> (past_ok && $past(dbe_evt[i] && dbe_trap_ok[i] && ecc_en[i])));

        assert_single_no_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sbe_evt[i] && !dbe_evt[i]) |=> !exc_req[i]);

        assert_unc_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            dbe_evt[i] |=> unc_flags[i]);
    end

endmodule

bind ecc_ctl_regs ecc_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_req     (csr_req),
    .csr_we      (csr_we),
    .csr_hit     (csr_hit),
    .csr_rvalid  (csr_rvalid),
    .csr_rdata   (csr_rdata),
    .sbe_evt     (sbe_evt),
    .dbe_evt     (dbe_evt),
    .dbe_trap_ok (dbe_trap_ok),
    .ecc_en      (ecc_en),
    .inj_code    (inj_code),
    .inj_sel     (inj_sel),
    .exc_req     (exc_req),
    .ecc_locked  (ecc_locked),
    .unc_flags   (unc_q)
);

// File: tb/tb_ecc_ctl_regs.sv
module tb_ecc_ctl_regs;
    import ecc_ctl_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                csr_req = 1'b0;
    logic                csr_we = 1'b0;
    logic [11:0]         csr_addr = '0;
    logic [XLEN-1:0]     csr_wdata = '0;
    logic                csr_hit;
    logic                csr_rvalid;
    logic [XLEN-1:0]     csr_rdata;
    logic [NUM_MEM-1:0]  sbe_evt = '0;
    logic [NUM_MEM-1:0]  dbe_evt = '0;
    logic [NUM_MEM-1:0]  dbe_trap_ok = '0;
    logic [NUM_MEM-1:0]  ecc_en;
    logic [CODE_W-1:0]   inj_code;
    logic                inj_sel;
    logic [NUM_MEM-1:0]  exc_req;
    logic                ecc_locked;

    int total = 0;
    int bad = 0;
    logic [XLEN-1:0] exp_q[$];
    string           tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    ecc_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_hit(csr_hit),
        .csr_rvalid(csr_rvalid), .csr_rdata(csr_rdata), .sbe_evt(sbe_evt),
        .dbe_evt(dbe_evt), .dbe_trap_ok(dbe_trap_ok), .ecc_en(ecc_en),
        .inj_code(inj_code), .inj_sel(inj_sel), .exc_req(exc_req),
        .ecc_locked(ecc_locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (rst_n && csr_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected response", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        csr_req = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] s, input logic [4:0] d, input logic [4:0] ok,
                         input logic [4:0] exp_exc, input string tag);
        @(negedge clk);
        sbe_evt = s; dbe_evt = d; dbe_trap_ok = ok;
        @(negedge clk);
        chk(tag, {27'd0, exc_req}, {27'd0, exp_exc});
        sbe_evt = '0; dbe_evt = '0; dbe_trap_ok = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ecc_en", {27'd0, ecc_en}, 32'h0);
        chk("R1 inj_code", {24'd0, inj_code}, 32'h0);
        chk("R1 inj_sel", {31'd0, inj_sel}, 32'h0);
        chk("R1 locked", {31'd0, ecc_locked}, 32'h0);
        chk("R1 exc_req", {27'd0, exc_req}, 32'h0);
        csr_read(A_ILM, 32'h0, "R1 read ilm");
        csr_read(A_INJ, 32'h0, "R1 read inj");
        csr_read(A_LOCK, 32'h0, "R1 read lock");

        // R2 control registers
        csr_write(A_ILM, 32'h3);
        csr_write(A_CACHE, 32'hFFFF_FFFF);
        csr_write(A_DLM, 32'h1);
        csr_write(A_TLB, 32'h2);
        csr_read(A_ILM, 32'h3, "R2 ilm");
        csr_read(A_CACHE, 32'hF, "R2 cache");
        csr_read(A_DLM, 32'h1, "R2 dlm");
        csr_read(A_TLB, 32'h2, "R2 tlb");
        chk("R2 ecc_en", {27'd0, ecc_en}, 32'h0F);

        // R3 injection code
        csr_write(A_INJ, 32'h0000_01A5);
        chk("R3 inj_code", {24'd0, inj_code}, 32'hA5);
        chk("R3 inj_sel", {31'd0, inj_sel}, 32'h1);
        csr_read(A_INJ, 32'h0000_01A5, "R3 read");

        // R4 single-bit on instruction cache
        pulse(5'b00100, 5'b0, 5'b0, 5'b0, "R4 no trap");
        csr_read(A_INJ, 32'h0004_01A5, "R4 flag");

        // R5/R6 double-bit cases
        pulse(5'b0, 5'b00001, 5'b00001, 5'b00001, "R6 ilm trap");
        pulse(5'b0, 5'b00010, 5'b00010, 5'b00000, "R6 dlm trap disabled");
        pulse(5'b0, 5'b10000, 5'b10000, 5'b00000, "R6 tlb ecc off");
        pulse(5'b0, 5'b01000, 5'b00000, 5'b00000, "R5 dcache not eligible");
        pulse(5'b0, 5'b00100, 5'b00100, 5'b00100, "R6 icache trap");
        csr_read(A_INJ, 32'h1F04_01A5, "R5 flags");

        // R7 clear by zero, keep by one
        csr_write(A_INJ, 32'h1E01_01A5);
        csr_read(A_INJ, 32'h1E00_01A5, "R7 partial clear");
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = A_INJ; csr_wdata = 32'h0000_01A5;
        dbe_evt = 5'b00010;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0; dbe_evt = '0;
        csr_read(A_INJ, 32'h0200_01A5, "R7 event wins");

        // R10 unknown address
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b0; csr_addr = 12'h7C3;
        exp_q.push_back(32'h0); tag_q.push_back("R10 miss data");
        #1 chk("R10 hit low", {31'd0, csr_hit}, 32'h0);
        @(negedge clk);
        csr_req = 1'b0;
        csr_write(12'h7C3, 32'hFFFF_FFFF);
        csr_read(A_ILM, 32'h3, "R10 no side effect");

        // R8 lock
        csr_write(A_LOCK, 32'h0);
        chk("R8 zero write", {31'd0, ecc_locked}, 32'h0);
        csr_write(A_LOCK, 32'h1);
        chk("R8 sealed", {31'd0, ecc_locked}, 32'h1);
        csr_read(A_LOCK, 32'h1, "R8 read");

        // R9 sealed behaviour
        csr_write(A_ILM, 32'h0);
        csr_read(A_ILM, 32'h3, "R9 ilm frozen");
        chk("R9 ecc_en", {27'd0, ecc_en}, 32'h0F);
        csr_write(A_INJ, 32'h0);
        csr_read(A_INJ, 32'h0200_01A5, "R9 inj frozen");
        chk("R9 inj_code", {24'd0, inj_code}, 32'hA5);
        csr_write(A_LOCK, 32'h0);
        chk("R9 lock stays", {31'd0, ecc_locked}, 32'h1);
        pulse(5'b0, 5'b00001, 5'b00001, 5'b00001, "R9 trap while sealed");
        pulse(5'b00010, 5'b0, 5'b0, 5'b0, "R9 sbe no trap");
        csr_read(A_INJ, 32'h0302_01A5, "R9 flags still set");

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule